// File: doc/BRIEF.md
# System Control Output Port

This block holds an 8-bit control port that drives two system-level lines: the gate for address line 20 and an active-low request that resets the processor. A command interpreter upstream updates the port in two ways. It can write the whole byte, or it can send one-byte commands. Those commands set or clear the A20 bit, read the port back, or ask for a timed low pulse on the run bit.

Any command whose upper nibble is all ones is a pulse command. Its low nibble is a mask, and a zero bit in the mask selects that port bit for pulsing. Only bit 0 does anything. When bit 0 of the command is zero, the reset request goes low for a programmable number of clock cycles. Any other value in that range does nothing. A full-byte write that leaves bit 0 at zero starts the same pulse.

The two buffer-full mirror bits come from outside the block, and the port readback shows them as they are. A readback command returns the current port value as a reply byte one cycle later.

Top module: `sysctl_port`

## Requirements
- R1: After reset the stored port is 0x03, `a20_gate` is 1, `rst_req_n` is 1, `reply_valid` is 0, and `port_value` equals 0x03 with bits 5:4 taken from `obf_flags`.
- R2: A cycle with `wr_valid` high stores `wr_data` into the port. From the next cycle on, `port_value` shows the written bits 7:6 and 3:0. Bits 5:4 of `port_value` always show `obf_flags[1:0]` and never the written data.
- R3: `a20_gate` equals stored port bit 1. It takes its new value in the cycle after a full write.
- R4: Command 0xDF sets port bit 1 and command 0xDD clears it, effective the next cycle. When a full write and one of these commands arrive in the same cycle, the command decides bit 1.
- R5: A full write with bit 0 equal to 0 drives `rst_req_n` low for exactly PULSE_CYC cycles, starting the next cycle. The written bit 0 stays stored.
- R6: A command in 0xF0..0xFF with bit 0 equal to 0 starts the same pulse as R5. A command in that range with bit 0 equal to 1 changes no output.
- R7: A new pulse trigger while a pulse is active reloads the full PULSE_CYC length, counted from the new trigger.
- R8: Command 0xD0 makes `reply_valid` high for exactly one cycle, the cycle after the command. `reply_byte` then carries the `port_value` that was present while the command was presented.
- R9: While `rst_req_n` is low, `port_value` bit 0 reads 0.
- R10: Command codes other than 0xD0, 0xDD, 0xDF and 0xF0..0xFF change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command byte is presented this cycle |
| cmd_byte | input | 8 | Command code |
| wr_valid | input | 1 | A full port write is presented this cycle |
| wr_data | input | 8 | New port byte |
| obf_flags | input | 2 | Buffer-full mirror bits shown at port bits 5:4 |
| a20_gate | output | 1 | Address line 20 gate level |
| rst_req_n | output | 1 | Active-low processor reset request |
| port_value | output | 8 | Current port readback |
| reply_valid | output | 1 | Reply byte is valid |
| reply_byte | output | 8 | Port value returned for a read command |

## Verification
Every register result lands one clock edge after its stimulus. The port byte, `a20_gate`, the start of the reset pulse and the readback reply all become visible in the cycle after the input is presented. `port_value` bits 5:4 follow `obf_flags` in the same cycle, with no register in between.

The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares every output on the next falling edge, so each comparison reads the state that was settled one edge after the stimulus. The pulse is checked cycle by cycle against a down-counter in the model, so a pulse that is one cycle too short or too long shows up at its first and last cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [7:0] CMD_READ_PORT = 8'hD0;
  localparam logic [7:0] CMD_A20_ON    = 8'hDF;
  localparam logic [7:0] CMD_A20_OFF   = 8'hDD;
  localparam logic [3:0] PULSE_NIBBLE  = 4'hF;

  localparam logic [7:0] PORT_RESET    = 8'h03;
  localparam int         RUN_BIT       = 0;
  localparam int         A20_BIT       = 1;
  localparam int         FLAG_LSB      = 4;
  localparam int         FLAG_W        = 2;

  typedef struct packed {
    logic a20_set;
    logic a20_clr;
    logic pulse;
    logic read;
  } ctl_t;

  function automatic logic pulse_selects_run(input logic [7:0] code);
    return (code[7:4] == PULSE_NIBBLE) && !code[RUN_BIT];
  endfunction

endpackage

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode
  import sysctl_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '0;
    if (cmd_valid) begin
      ctl.a20_set = (cmd_byte == CMD_A20_ON);
      ctl.a20_clr = (cmd_byte == CMD_A20_OFF);
      ctl.read    = (cmd_byte == CMD_READ_PORT);
      ctl.pulse   = pulse_selects_run(cmd_byte);
    end
  end

endmodule

// File: rtl/sysctl_port_reg.sv
module sysctl_port_reg
  import sysctl_pkg::*;
#(
  parameter int          WIDTH     = 8,
  parameter logic [WIDTH-1:0] RST_VAL = PORT_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             a20_set,
  input  logic             a20_clr,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] d;
  logic             en;

  always_comb begin
    d = q;
    if (wr_en)   d = wr_data;
    if (a20_set) d[A20_BIT] = 1'b1;
    if (a20_clr) d[A20_BIT] = 1'b0;
  end

  assign en = wr_en | a20_set | a20_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end

endmodule

// File: rtl/sysctl_pulse_timer.sv
module sysctl_pulse_timer #(
  parameter int PULSE_CYC = 300,
  localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (trigger) begin
      cnt_d  = CNT_W'(PULSE_CYC);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sysctl_reply.sv
module sysctl_reply #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDTH-1:0] snap,
  output logic             valid,
  output logic [WIDTH-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data <= '0;
    else if (req) data <= snap;
  end

endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
#(
  parameter int PULSE_CYC = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [1:0] obf_flags,
  output logic       a20_gate,
  output logic       rst_req_n,
  output logic [7:0] port_value,
  output logic       reply_valid,
  output logic [7:0] reply_byte
);

  ctl_t       ctl;
  logic [7:0] port_q;
  logic       pulse_trig;
  logic       pulse_busy;

  sysctl_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .ctl       (ctl)
  );

  sysctl_port_reg #(.WIDTH(8), .RST_VAL(PORT_RESET)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .a20_set (ctl.a20_set),
    .a20_clr (ctl.a20_clr),
    .q       (port_q)
  );

  assign pulse_trig = ctl.pulse | (wr_valid & ~wr_data[RUN_BIT]);

  sysctl_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (pulse_trig),
    .busy    (pulse_busy)
  );

  always_comb begin
    port_value = port_q;
    port_value[FLAG_LSB +: FLAG_W] = obf_flags;
    port_value[RUN_BIT] = port_q[RUN_BIT] & ~pulse_busy;
  end

  sysctl_reply #(.WIDTH(8)) u_rep (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ctl.read),
    .snap  (port_value),
    .valid (reply_valid),
    .data  (reply_byte)
  );

  assign a20_gate  = port_q[A20_BIT];
  assign rst_req_n = ~pulse_busy;

endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
  parameter int PULSE_CYC = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       a20_gate,
  input logic       rst_req_n,
  input logic [7:0] port_value,
  input logic       reply_valid,
  input logic [7:0] reply_byte
);

  logic        trig;
  logic [31:0] left_q;

  assign trig = (cmd_valid && cmd_byte[7:4] == 4'hF && !cmd_byte[0]) ||
                (wr_valid && !wr_data[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (trig)         left_q <= 32'(PULSE_CYC);
    else if (left_q != '0) left_q <= left_q - 32'd1;
  end

  // R4
  a20_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'hDF) |=> a20_gate);

  // R4
  a20_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'hDD) |=> !a20_gate);

  // R5
  wr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_data[0]) |=> !rst_req_n);

  // R6
  pulse_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:4] == 4'hF && !cmd_byte[0]) |=> !rst_req_n);

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_n == (left_q == '0));

  // R8
  reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'hD0) |=> (reply_valid && reply_byte == $past(port_value)));

  // R8
  reply_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_byte == 8'hD0) |=> !reply_valid);

  // R9
  run_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |-> !port_value[0]);

endmodule

bind sysctl_port sysctl_port_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_byte    (cmd_byte),
  .wr_valid    (wr_valid),
  .wr_data     (wr_data),
  .a20_gate    (a20_gate),
  .rst_req_n   (rst_req_n),
  .port_value  (port_value),
  .reply_valid (reply_valid),
  .reply_byte  (reply_byte)
);

// File: tb/sysctl_port_test.sv
module sysctl_port_test;

  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, wr_valid;
  logic [7:0] cmd_byte, wr_data;
  logic [1:0] obf_flags;
  logic       a20_gate, rst_req_n, reply_valid;
  logic [7:0] port_value, reply_byte;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // reference model state
  int m_port, m_cnt, m_rv, m_rb;

  always #10 clk = ~clk;

  sysctl_port #(.PULSE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_data(wr_data), .obf_flags(obf_flags),
    .a20_gate(a20_gate), .rst_req_n(rst_req_n), .port_value(port_value),
    .reply_valid(reply_valid), .reply_byte(reply_byte)
  );

  function automatic int exp_pv();
    int v;
    v = m_port & 8'hCF;
    v = v | (int'(obf_flags) << 4);
    if (m_cnt != 0) v = v & 8'hFE;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_port = 8'h03; m_cnt = 0; m_rv = 0; m_rb = 0;
    end else begin
      int pv;
      bit trig;
      pv   = exp_pv();
      trig = 0;
      m_rv = (cmd_valid && cmd_byte == 8'hD0) ? 1 : 0;
      if (m_rv != 0) m_rb = pv;
      if (wr_valid) begin
        m_port = int'(wr_data);
        if (!wr_data[0]) trig = 1;
      end
      if (cmd_valid) begin
        if (cmd_byte == 8'hDF) m_port = m_port | 2;
        if (cmd_byte == 8'hDD) m_port = m_port & 8'hFD;
        if (cmd_byte[7:4] == 4'hF && !cmd_byte[0]) trig = 1;
      end
      if (trig) m_cnt = P;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R2/R9 port_value", int'(port_value), exp_pv());
    chk("R3/R4 a20_gate", int'(a20_gate), (m_port >> 1) & 1);
    chk("R5/R6/R7 rst_req_n", int'(rst_req_n), (m_cnt == 0) ? 1 : 0);
    chk("R8 reply_valid", int'(reply_valid), m_rv);
    if (m_rv != 0) chk("R8 reply_byte", int'(reply_byte), m_rb);
  endtask

  task automatic step(bit cv, logic [7:0] cb, bit wv, logic [7:0] wd, logic [1:0] fl);
    @(negedge clk);
    compare_all();
    cmd_valid = cv; cmd_byte = cb; wr_valid = wv; wr_data = wd; obf_flags = fl;
  endtask

  task automatic idle(int n, logic [1:0] fl);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, fl);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_byte = 0; wr_valid = 0; wr_data = 0; obf_flags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state against constants
    chk("R1 port_value", int'(port_value), 8'h03);
    chk("R1 a20_gate", int'(a20_gate), 1);
    chk("R1 rst_req_n", int'(rst_req_n), 1);
    chk("R1 reply_valid", int'(reply_valid), 0);
    idle(2, 2'b01);                        // R2: flags reach bits 5:4
    step(0, 8'h00, 1, 8'hFB, 2'b00);       // R2/R3: full write, bits 5:4 ignored
    step(0, 8'h00, 1, 8'h41, 2'b10);       // R3: A20 off by write
    step(1, 8'hDF, 0, 8'h00, 2'b10);       // R4 set
    step(1, 8'hD0, 0, 8'h00, 2'b11);       // R8 read back
    step(1, 8'hDD, 0, 8'h00, 2'b11);       // R4 clear
    step(1, 8'hD0, 0, 8'h00, 2'b00);       // R8
    step(1, 8'hDD, 1, 8'h03, 2'b00);       // R4: command wins bit 1
    step(1, 8'hDF, 1, 8'h81, 2'b00);       // R4
    step(1, 8'hFF, 0, 8'h00, 2'b00);       // R6 no-op code
    step(1, 8'hF3, 0, 8'h00, 2'b01);       // R6 no-op code
    idle(2, 2'b01);
    step(1, 8'hFE, 0, 8'h00, 2'b00);       // R6 pulse, R9 bit 0 low
    idle(3, 2'b00);
    step(1, 8'hD0, 0, 8'h00, 2'b00);       // R8 during pulse
    idle(P + 2, 2'b00);
    step(0, 8'h00, 1, 8'h02, 2'b00);       // R5 write with bit 0 clear
    idle(4, 2'b00);
    step(1, 8'hF0, 0, 8'h00, 2'b00);       // R7 restart
    idle(P + 3, 2'b00);
    step(0, 8'h00, 1, 8'h03, 2'b00);
    step(1, 8'hFA, 0, 8'h00, 2'b00);       // R6 pulse code with other bits
    idle(2, 2'b00);
    step(0, 8'h00, 1, 8'hFE, 2'b00);       // R7 retrigger by write
    idle(P + 2, 2'b00);
    step(0, 8'h00, 1, 8'h03, 2'b00);
    step(1, 8'h20, 0, 8'h00, 2'b00);       // R10 unrelated commands
    step(1, 8'hA8, 0, 8'h00, 2'b01);       // R10
    step(1, 8'hD1, 0, 8'h00, 2'b10);       // R10
    idle(3, 2'b11);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule